// File: doc/BRIEF.md
# Ethernet Receive Address Filter with Station Address Table

This block decides, for each incoming frame, whether its 48-bit destination address is wanted by the station and how it is classified. It holds a table of station addresses with a per-entry enable mask. It also takes three mode inputs: accept every unicast frame, accept every group-addressed frame, and accept the all-ones broadcast address. Each decision comes out one clock after a destination-valid strobe as an accept bit, a broadcast flag and a multicast flag.

The table is filled through a word-wide load port. A load command carries an entry count. The entry words then arrive one per valid cycle, followed by a final word that sets the enable mask, and a one-cycle completion pulse marks the end of the load. A debug read port returns any stored entry word, but only while the surrounding controller reports that it is held in reset. At any other time the port reads zero.

Address byte convention used throughout: byte k of a 48-bit address (byte 0 is the first byte on the wire) sits at bits [8k+7:8k]. A group (multicast) address has bit 0 of byte 0 set.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, flt_valid, flt_accept, flt_bcast, flt_mcast, ld_busy and ld_done are 0, every table entry reads back as 0, and the enable mask is 0, so no address matches the table.
- R2: flt_valid is 1 in exactly the cycle after a cycle with dst_valid high. The mode inputs and dst_addr are sampled in the dst_valid cycle. flt_accept, flt_bcast and flt_mcast are 0 whenever flt_valid is 0.
- R3: If mode_promisc is 1 and bit 0 of byte 0 is 0, the frame is accepted with neither flag set. This check has the highest priority.
- R4: Otherwise, if mode_all_mcast is 1 and bit 0 of byte 0 is 1, the frame is accepted with flt_mcast set. This check takes priority over the broadcast check, so with both modes on, the all-ones address gets the multicast flag.
- R5: Otherwise, if mode_bcast is 1 and all six bytes are 0xFF, the frame is accepted with flt_bcast set.
- R6: Otherwise, the frame is accepted with no flag exactly when its address equals an entry whose enable-mask bit is set. A matching entry whose mask bit is clear does not accept the frame, and no match rejects it.
- R7: Each entry is loaded from three words in the order word 0, word 1, word 2. Word j holds address byte 2j in bits [7:0] and address byte 2j+1 in bits [15:8].
- R8: A pulse on ld_start loads the low 5 bits of ld_count as the entry count, resets the entry index to 0 and sets ld_busy. The upper count bits are ignored. While ld_busy is high, each ld_valid word is stored. After every third word of an entry the count decrements and the index advances, wrapping modulo the table depth.
- R9: When the count is zero, the next ld_valid word sets the enable mask (bit i enables entry i). ld_busy then falls, and ld_done is high for exactly one cycle after that word. A count of zero loads only the mask.
- R10: While in_reset is 1, dbg_data returns word dbg_sel (0, 1 or 2, as in R7) of entry dbg_ptr[3:0]; dbg_sel of 3 returns 0. While in_reset is 0, dbg_data is 0.
- R11: ld_valid words that arrive while ld_busy is 0 change neither the table nor the mask.
- R12: With only mode_promisc on, a group address that matches no enabled entry is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_promisc | input | 1 | Accept all unicast addresses |
| mode_all_mcast | input | 1 | Accept all group addresses |
| mode_bcast | input | 1 | Accept the all-ones broadcast address |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte k at [8k+7:8k] |
| flt_valid | output | 1 | Decision valid |
| flt_accept | output | 1 | Frame accepted |
| flt_bcast | output | 1 | Accepted as broadcast |
| flt_mcast | output | 1 | Accepted as multicast |
| ld_start | input | 1 | Begin table load |
| ld_count | input | 16 | Entry count (low 5 bits used) |
| ld_valid | input | 1 | Load word strobe |
| ld_word | input | 16 | Load word |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle load-complete pulse |
| in_reset | input | 1 | Controller held in reset; enables readback |
| dbg_ptr | input | 8 | Entry pointer (low 4 bits used) |
| dbg_sel | input | 2 | Word select within the entry |
| dbg_data | output | 16 | Readback word |

## Verification
The bench builds the block with its defaults: 16 entries, a 5-bit count and an 8-bit pointer. With these values a count of 17 or more can be loaded, which makes the index wrap onto entry 0. The full 16-bit mask can be exercised, including disabled entries that would otherwise match, and pointer bits above the table index are shown to be ignored. Random addresses are drawn from table hits, near-misses, group addresses and the broadcast address under random mode settings, so every branch of the priority order is reached, including the overlap between the multicast and broadcast checks.

// File: rtl/rxf_pkg.sv
// Shared types and helpers for the receive address filter.
// Assumes 48-bit addresses with byte k at bits [8k+7:8k].
package rxf_pkg;
    localparam int MAC_W     = 48;
    localparam int WORD_W    = 16;
    localparam int ENT_WORDS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MAC_W-1:0]  mac_t;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
    } verdict_t;

    // Group addresses carry a set bit 0 in the first byte.
    function automatic logic is_group(input mac_t a);
        return a[0];
    endfunction

    // The broadcast address is all ones.
    function automatic logic is_all_ones(input mac_t a);
        return &a;
    endfunction
endpackage

// File: rtl/rxf_cam_store.sv
// Station address table storage with its word-serial loader and the
// reset-only debug readback. Each entry is three words, low byte first.
// Assumes N_ENTRIES <= WORD_W so that one word carries the enable mask.
module rxf_cam_store
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 5,
    parameter int CNT_IN_W  = 16,
    parameter int PTR_W     = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_start,
    input  logic [CNT_IN_W-1:0]        ld_count,
    input  logic                       ld_valid,
    input  word_t                      ld_word,
    output logic                       ld_busy,
    output logic                       ld_done,
    input  logic                       in_reset,
    input  logic [PTR_W-1:0]           dbg_ptr,
    input  logic [1:0]                 dbg_sel,
    output word_t                      dbg_data,
    output logic [N_ENTRIES*MAC_W-1:0] tab_flat,
    output logic [N_ENTRIES-1:0]       en_mask
);
    word_t              tab_q [N_ENTRIES][ENT_WORDS];
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [1:0]         wsel_q;
    logic               busy_q;
    logic               done_q;
    logic [N_ENTRIES-1:0] mask_q;

    logic unused_cnt_hi;
    logic unused_ptr_hi;
    logic unused_word_hi;
    assign unused_cnt_hi  = ^ld_count[CNT_IN_W-1:CNT_W];
    assign unused_ptr_hi  = ^dbg_ptr[PTR_W-1:IDX_W];
    assign unused_word_hi = (N_ENTRIES < WORD_W) ? ^ld_word : 1'b0;

    // Loader sequencer: count, index and word-select bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            wsel_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            mask_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (ld_start) begin
                cnt_q  <= ld_count[CNT_W-1:0];
                idx_q  <= '0;
                wsel_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q && ld_valid) begin
                if (cnt_q == '0) begin
                    mask_q <= ld_word[N_ENTRIES-1:0];
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else if (wsel_q == 2'd2) begin
                    wsel_q <= '0;
                    idx_q  <= idx_q + 1'b1;
                    cnt_q  <= cnt_q - 1'b1;
                end else begin
                    wsel_q <= wsel_q + 1'b1;
                end
            end
        end
    end

    // Table storage: write the word addressed by index and word select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENTRIES; e++) begin
                for (int w = 0; w < ENT_WORDS; w++) begin
                    tab_q[e][w] <= '0;
                end
            end
        end else if (!ld_start && busy_q && ld_valid && cnt_q != '0) begin
            tab_q[idx_q][wsel_q] <= ld_word;
        end
    end

    // Flatten each entry into a 48-bit address for the matcher.
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_flat
        assign tab_flat[e*MAC_W +: MAC_W] = {tab_q[e][2], tab_q[e][1], tab_q[e][0]};
    end

    // Debug readback, only while the controller is in reset.
    always_comb begin
        dbg_data = '0;
        if (in_reset && dbg_sel != 2'd3) begin
            dbg_data = tab_q[dbg_ptr[IDX_W-1:0]][dbg_sel];
        end
    end

    assign ld_busy = busy_q;
    assign ld_done = done_q;
    assign en_mask = mask_q;
endmodule

// File: rtl/rxf_cam_match.sv
// Parallel comparison of one destination address against every table
// entry, gated by the enable mask. Purely combinational.
module rxf_cam_match
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16
) (
    input  mac_t                       addr,
    input  logic [N_ENTRIES*MAC_W-1:0] tab_flat,
    input  logic [N_ENTRIES-1:0]       en_mask,
    output logic                       any_hit
);
    logic [N_ENTRIES-1:0] hit;

    // One comparator per entry.
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        assign hit[e] = en_mask[e] && (tab_flat[e*MAC_W +: MAC_W] == addr);
    end

    assign any_hit = |hit;
endmodule

// File: rtl/rxf_decide.sv
// Priority decision and output register. Order: unicast-all mode,
// group-all mode, broadcast mode, then table hit.
module rxf_decide
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dst_valid,
    input  mac_t dst_addr,
    input  logic mode_promisc,
    input  logic mode_all_mcast,
    input  logic mode_bcast,
    input  logic any_hit,
    output logic flt_valid,
    output logic flt_accept,
    output logic flt_bcast,
    output logic flt_mcast
);
    verdict_t v_d;
    verdict_t v_q;
    logic     valid_q;

    // Walk the priority chain for the current address.
    always_comb begin
        v_d = '0;
        if (mode_promisc && !is_group(dst_addr)) begin
            v_d.accept = 1'b1;
        end else if (mode_all_mcast && is_group(dst_addr)) begin
            v_d.accept = 1'b1;
            v_d.mcast  = 1'b1;
        end else if (mode_bcast && is_all_ones(dst_addr)) begin
            v_d.accept = 1'b1;
            v_d.bcast  = 1'b1;
        end else begin
            v_d.accept = any_hit;
        end
    end

    // Register the verdict one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            v_q     <= '0;
        end else begin
            valid_q <= dst_valid;
            v_q     <= dst_valid ? v_d : '0;
        end
    end

    assign flt_valid  = valid_q;
    assign flt_accept = v_q.accept;
    assign flt_bcast  = v_q.bcast;
    assign flt_mcast  = v_q.mcast;
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter: address table with loader and
// readback, parallel matcher, and registered priority decision.
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = 5,
    parameter int CNT_IN_W  = 16,
    parameter int PTR_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_promisc,
    input  logic                mode_all_mcast,
    input  logic                mode_bcast,
    input  logic                dst_valid,
    input  logic [47:0]         dst_addr,
    output logic                flt_valid,
    output logic                flt_accept,
    output logic                flt_bcast,
    output logic                flt_mcast,
    input  logic                ld_start,
    input  logic [CNT_IN_W-1:0] ld_count,
    input  logic                ld_valid,
    input  logic [15:0]         ld_word,
    output logic                ld_busy,
    output logic                ld_done,
    input  logic                in_reset,
    input  logic [PTR_W-1:0]    dbg_ptr,
    input  logic [1:0]          dbg_sel,
    output logic [15:0]         dbg_data
);
    logic [N_ENTRIES*MAC_W-1:0] tab_flat;
    logic [N_ENTRIES-1:0]       en_mask;
    logic                       any_hit;

    rxf_cam_store #(
        .N_ENTRIES(N_ENTRIES), .CNT_W(CNT_W),
        .CNT_IN_W(CNT_IN_W), .PTR_W(PTR_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .ld_start(ld_start), .ld_count(ld_count),
        .ld_valid(ld_valid), .ld_word(ld_word),
        .ld_busy(ld_busy), .ld_done(ld_done),
        .in_reset(in_reset), .dbg_ptr(dbg_ptr), .dbg_sel(dbg_sel),
        .dbg_data(dbg_data), .tab_flat(tab_flat), .en_mask(en_mask)
    );

    rxf_cam_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .addr(dst_addr), .tab_flat(tab_flat),
        .en_mask(en_mask), .any_hit(any_hit)
    );

    rxf_decide u_decide (
        .clk(clk), .rst_n(rst_n),
        .dst_valid(dst_valid), .dst_addr(dst_addr),
        .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast),
        .mode_bcast(mode_bcast), .any_hit(any_hit),
        .flt_valid(flt_valid), .flt_accept(flt_accept),
        .flt_bcast(flt_bcast), .flt_mcast(flt_mcast)
    );
endmodule

// File: rtl/rxf_checker.sv
// Port-level properties of the address filter, bound to the top module.
module rxf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_promisc,
    input logic        mode_all_mcast,
    input logic        dst_valid,
    input logic [47:0] dst_addr,
    input logic        flt_valid,
    input logic        flt_accept,
    input logic        flt_bcast,
    input logic        flt_mcast,
    input logic        ld_done,
    input logic        in_reset,
    input logic [1:0]  dbg_sel,
    input logic [15:0] dbg_data
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> flt_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> !flt_valid); // R2
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |-> !(flt_accept || flt_bcast || flt_mcast)); // R2
    AST_PROMISC_UNICAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && mode_promisc && !dst_addr[0])
            |=> (flt_accept && !flt_bcast && !flt_mcast)); // R3
    AST_MCAST_OVER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !mode_promisc && mode_all_mcast && dst_addr[0])
            |=> (flt_accept && flt_mcast && !flt_bcast)); // R4
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flt_bcast, flt_mcast})); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done); // R9
    AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_reset || dbg_sel == 2'd3) |-> (dbg_data == 16'h0)); // R10
endmodule

bind rx_addr_filter rxf_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast),
    .dst_valid(dst_valid), .dst_addr(dst_addr),
    .flt_valid(flt_valid), .flt_accept(flt_accept),
    .flt_bcast(flt_bcast), .flt_mcast(flt_mcast),
    .ld_done(ld_done), .in_reset(in_reset),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
);

// File: tb/tb_rx_addr_filter.sv
// Self-checking bench: directed corners plus seeded random addresses,
// compared with a bench-side model of the table and priority rules.
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_promisc = 0, mode_all_mcast = 0, mode_bcast = 0;
    logic        dst_valid = 0;
    logic [47:0] dst_addr = '0;
    logic        flt_valid, flt_accept, flt_bcast, flt_mcast;
    logic        ld_start = 0, ld_valid = 0;
    logic [15:0] ld_count = '0, ld_word = '0;
    logic        ld_busy, ld_done;
    logic        in_reset = 0;
    logic [7:0]  dbg_ptr = '0;
    logic [1:0]  dbg_sel = '0;
    logic [15:0] dbg_data;

    int n_chk = 0, n_bad = 0;
    logic [47:0] m_tab [16];
    logic [15:0] m_mask = '0;

    always #5 clk = ~clk;

    rx_addr_filter dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_verdict(input logic [47:0] a, input bit p, input bit m, input bit b);
        bit hit = 0;
        for (int i = 0; i < 16; i++) if (m_mask[i] && m_tab[i] == a) hit = 1;
        if (p && !a[0]) return 3'b100;
        if (m && a[0]) return 3'b101;
        if (b && a == 48'hFFFF_FFFF_FFFF) return 3'b110;
        return {hit, 2'b00};
    endfunction

    task automatic probe(input logic [47:0] a, input bit p, input bit m, input bit b, input string req);
        logic [2:0] e;
        e = exp_verdict(a, p, m, b);
        @(negedge clk);
        dst_addr = a; mode_promisc = p; mode_all_mcast = m; mode_bcast = b; dst_valid = 1;
        @(negedge clk);
        dst_valid = 0;
        chk(flt_valid == 1'b1, "R2", {63'd0, flt_valid}, 64'd1);
        chk({flt_accept, flt_bcast, flt_mcast} == e, req, {61'd0, flt_accept, flt_bcast, flt_mcast}, {61'd0, e});
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        ld_valid = 1; ld_word = w;
    endtask

    // Load cnt_raw entries (low 5 bits count) with given addresses, then the mask.
    task automatic load_table(input logic [15:0] cnt_raw, input logic [15:0] mask, input bit rnd);
        int n;
        logic [47:0] a;
        n = int'(cnt_raw[4:0]);
        @(negedge clk);
        ld_valid = 0; ld_start = 1; ld_count = cnt_raw;
        @(negedge clk);
        ld_start = 0;
        for (int k = 0; k < n; k++) begin
            a = rnd ? {$urandom(), $urandom()} : 48'h0200_0000_0000 + 48'(k);
            m_tab[k % 16] = a;
            send_word(a[15:0]); send_word(a[31:16]); send_word(a[47:32]);
        end
        send_word(mask);
        m_mask = mask;
        @(negedge clk);
        ld_valid = 0;
        chk(ld_done == 1'b1 && ld_busy == 1'b0, "R9", {62'd0, ld_done, ld_busy}, 64'd2);
        @(negedge clk);
        chk(ld_done == 1'b0, "R9", {63'd0, ld_done}, 64'd0);
    endtask

    task automatic read_word(input logic [7:0] ptr, input logic [1:0] sel, input logic [15:0] exp, input string req);
        @(negedge clk);
        dbg_ptr = ptr; dbg_sel = sel;
        #1;
        chk(dbg_data == exp, req, {48'd0, dbg_data}, {48'd0, exp});
    endtask

    // Watchdog: a hung run is one failed check and still summarizes.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [47:0] a;
        int pick;
        seed = $urandom(32'd4711);
        for (int i = 0; i < 16; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk({flt_valid, flt_accept, flt_bcast, flt_mcast, ld_busy, ld_done} == 6'b0, "R1",
            {58'd0, flt_valid, flt_accept, flt_bcast, flt_mcast, ld_busy, ld_done}, 64'd0);
        in_reset = 1;
        read_word(8'd5, 2'd1, 16'h0, "R1");
        in_reset = 0;
        probe(48'h0, 0, 0, 0, "R1");

        // R7/R10: directed load and readback, byte order
        @(negedge clk);
        ld_start = 1; ld_count = 16'd1;
        @(negedge clk);
        ld_start = 0;
        send_word(16'h2211); send_word(16'h4433); send_word(16'h6655);
        send_word(16'h0001);
        @(negedge clk);
        ld_valid = 0;
        m_tab[0] = 48'h6655_4433_2211; m_mask = 16'h0001;
        probe(48'h6655_4433_2211, 0, 0, 0, "R7");
        probe(48'h1122_3344_5566, 0, 0, 0, "R7");
        in_reset = 1;
        read_word(8'h00, 2'd0, 16'h2211, "R10");
        read_word(8'hF0, 2'd2, 16'h6655, "R10");
        read_word(8'h00, 2'd3, 16'h0000, "R10");
        in_reset = 0;
        read_word(8'h00, 2'd0, 16'h0000, "R10");

        // R11: stray words with no load in progress
        send_word(16'h0000); send_word(16'hBEEF);
        @(negedge clk); ld_valid = 0;
        probe(48'h6655_4433_2211, 0, 0, 0, "R11");

        // R8: upper count bits ignored (0x0022 -> 2 entries)
        load_table(16'h0022, 16'h0002, 0);
        probe(48'h0200_0000_0000, 0, 0, 0, "R6");
        probe(48'h0200_0000_0001, 0, 0, 0, "R8");
        in_reset = 1;
        read_word(8'd1, 2'd0, 16'h0001, "R8");
        in_reset = 0;

        // R9: zero count loads only the mask
        load_table(16'h0000, 16'h0003, 0);
        probe(48'h0200_0000_0000, 0, 0, 0, "R9");

        // R8: index wrap with 17 entries overwrites entry 0
        load_table(16'd17, 16'hFFFF, 0);
        probe(48'h0200_0000_0010, 0, 0, 0, "R8");
        probe(48'h0200_0000_0000, 0, 0, 0, "R8");

        // Priority corners
        probe(48'hFFFF_FFFF_FFFF, 0, 1, 1, "R4");
        probe(48'hFFFF_FFFF_FFFF, 0, 0, 1, "R5");
        probe(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R5");
        probe(48'h1234_5678_9A00, 1, 0, 0, "R3");
        probe(48'h1234_5678_9A01, 1, 0, 0, "R12");
        probe(48'h1234_5678_9A01, 1, 1, 0, "R4");
        probe(48'h0200_0000_0003, 0, 0, 0, "R6");
        @(negedge clk);
        chk(flt_valid == 1'b0 && flt_accept == 1'b0, "R2", {62'd0, flt_valid, flt_accept}, 64'd0);

        // Random phase
        load_table(16'd16, 16'(($urandom() | 32'h1) & 32'hFFFF), 1);
        for (int t = 0; t < 300; t++) begin
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = m_tab[$urandom_range(0, 15)];
                1: begin a = m_tab[$urandom_range(0, 15)]; a[47:40] ^= 8'h80; end
                2: a = 48'hFFFF_FFFF_FFFF;
                3: a = {$urandom(), $urandom()} | 48'h1;
                default: a = {$urandom(), $urandom()};
            endcase
            probe(a, 1'($urandom()), 1'($urandom()), 1'($urandom()), "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule